// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Serialization

This block is the scratchpad of a multithreaded compute core. One request set comes from a group of 16 threads. For each thread the set carries a valid flag, a read/write flag, a word address and write data. The storage is split into 16 single-port banks, one 32-bit word wide. A bank is selected by the low bits of the word address, so consecutive words fall in consecutive banks.

Once a set is accepted, the block groups the pending requests by bank. In every cycle each bank serves one word. Requests that land in different banks proceed together. Requests to different words of the same bank are spread over later cycles. Threads that name the very same word are merged into a single access, so a broadcast read, or a repeated write, costs nothing extra. When every request has been served, the block pulses a done flag and presents the per-thread read data. While a set is in progress, busy is high and further sets are refused.

Top module: `bsm_scratch`

## Requirements
- R1: A 12-bit word address selects bank `addr[3:0]` and row `addr[11:4]`. There are 16 banks of 256 words, 16 KB in total.
- R2: `req_start` is accepted only on a clock edge where `busy` is low. `busy` is high from the next cycle until done. While `busy` is high, `req_start` and all request inputs are ignored.
- R3: Let N be the largest number of distinct valid addresses that fall in any one bank, with N taken as 1 when no request is valid. `done` is a single-cycle pulse. It rises, and `busy` falls, N+1 clock edges after the accepting edge.
- R4: Every valid thread receives in `rd_data` the content its word had before the set began. This holds for readers and writers, and for threads merged on one address (broadcast). Writes of the same set are not visible to its reads.
- R5: After the set, each word written by a valid thread holds that thread's data. When several valid threads write the same word, the highest-numbered thread's data is kept.
- R6: A thread whose valid bit is 0 receives zero in `rd_data`.
- R7: Requests whose valid bit is 0 leave memory unchanged.
- R8: During and after reset, `busy` and `done` are 0 and `rd_data` is all zeros.
- R9: In every serving cycle with requests still pending, at least one pending request is retired. Each bank serves its lowest-numbered pending thread, together with all threads that share that thread's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Offer a request set (taken when busy is low) |
| req_valid | input | 16 | Per-thread request valid |
| req_we | input | 16 | Per-thread write (1) or read (0) |
| req_addr | input | 16 x 12 | Per-thread word address |
| req_wdata | input | 16 x 32 | Per-thread write data |
| busy | output | 1 | Request set in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 x 32 | Per-thread read data, valid with done |

## Verification
The bench computes N for each set from the addresses it drives. It counts clock edges after the accepting edge and expects `done`, with `busy` low, on edge N+1 exactly. The outputs are sampled on the falling edge that follows. `rd_data` is compared on that same sample against a bench memory image taken before the set. The set's writes are applied to the image only afterwards, in ascending thread order. Refused sets and invalid writes are checked later through ordinary read sets, which must return the image unchanged.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int SM_THREADS = 16;
  localparam int SM_BANKS   = 16;
  localparam int SM_ROWS    = 256;
  localparam int SM_WORD    = 32;
endpackage

// File: rtl/bsm_bank_ram.sv
module bsm_bank_ram #(
  parameter int ROWS = 256,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [ROWS];

  // read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/bsm_bank_pick.sv
module bsm_bank_pick #(
  parameter int NTHR    = 16,
  parameter int BW      = 4,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic [NTHR-1:0]         pend,
  input  logic [NTHR-1:0][AW-1:0] addr,
  input  logic [NTHR-1:0]         we,
  input  logic [NTHR-1:0][DW-1:0] wdata,
  output logic [NTHR-1:0]         grant,
  output logic                    en,
  output logic                    wr,
  output logic [AW-BW-1:0]        row,
  output logic [DW-1:0]           wdata_o
);
  localparam logic [BW-1:0] MYB = BW'(BANK_ID);

  logic          found;
  logic [AW-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    // lowest-numbered pending thread of this bank sets the word
    for (int t = 0; t < NTHR; t++) begin
      if (!found && pend[t] && addr[t][BW-1:0] == MYB) begin
        found = 1'b1;
        sel   = addr[t];
      end
    end
    grant   = '0;
    wr      = 1'b0;
    wdata_o = '0;
    // merge same-word threads; the highest writer wins
    for (int t = 0; t < NTHR; t++) begin
      if (found && pend[t] && addr[t] == sel) begin
        grant[t] = 1'b1;
        if (we[t]) begin
          wr      = 1'b1;
          wdata_o = wdata[t];
        end
      end
    end
  end

  assign en  = found;
  assign row = sel[AW-1:BW];
endmodule

// File: rtl/bsm_scratch.sv
module bsm_scratch
  import bsm_pkg::*;
#(
  parameter int NTHR  = SM_THREADS,
  parameter int NBANK = SM_BANKS,
  parameter int ROWS  = SM_ROWS,
  parameter int DW    = SM_WORD,
  localparam int BW   = $clog2(NBANK),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_start,
  input  logic [NTHR-1:0]         req_valid,
  input  logic [NTHR-1:0]         req_we,
  input  logic [NTHR-1:0][AW-1:0] req_addr,
  input  logic [NTHR-1:0][DW-1:0] req_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [NTHR-1:0][DW-1:0] rd_data
);
  logic [NTHR-1:0]         pend_q, we_q, served_q;
  logic [NTHR-1:0][AW-1:0] addr_q;
  logic [NTHR-1:0][DW-1:0] wd_q, rd_q;
  logic                    busy_q, done_q, last_q;

  logic [NTHR-1:0]              act_pend, serve;
  logic [NBANK-1:0][NTHR-1:0]   gnt;
  logic [NBANK-1:0]             b_en, b_we;
  logic [NBANK-1:0][RW-1:0]     b_row;
  logic [NBANK-1:0][DW-1:0]     b_wd, b_q;

  assign act_pend = busy_q ? pend_q : '0;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bsm_bank_pick #(
      .NTHR(NTHR), .BW(BW), .AW(AW), .DW(DW), .BANK_ID(g)
    ) u_pick (
      .pend(act_pend), .addr(addr_q), .we(we_q), .wdata(wd_q),
      .grant(gnt[g]), .en(b_en[g]), .wr(b_we[g]), .row(b_row[g]),
      .wdata_o(b_wd[g])
    );
    bsm_bank_ram #(.ROWS(ROWS), .DW(DW)) u_ram (
      .clk(clk), .en(b_en[g]), .we(b_we[g]), .row(b_row[g]),
      .wdata(b_wd[g]), .rdata(b_q[g])
    );
  end

  always_comb begin
    serve = '0;
    for (int b = 0; b < NBANK; b++) serve = serve | gnt[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      last_q   <= 1'b0;
      pend_q   <= '0;
      served_q <= '0;
      rd_q     <= '0;
      we_q     <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_start) begin
          busy_q   <= 1'b1;
          pend_q   <= req_valid;
          we_q     <= req_we;
          addr_q   <= req_addr;
          wd_q     <= req_wdata;
          rd_q     <= '0;
          served_q <= '0;
          last_q   <= 1'b0;
        end
      end else begin
        // bank output is one cycle behind its grant
        for (int t = 0; t < NTHR; t++)
          if (served_q[t]) rd_q[t] <= b_q[addr_q[t][BW-1:0]];
        if (last_q) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          last_q   <= 1'b0;
          served_q <= '0;
        end else begin
          pend_q   <= pend_q & ~serve;
          served_q <= serve;
          last_q   <= ((act_pend & ~serve) == '0);
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q))); // R3
  AST_REFUSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ((pend_q & ~$past(pend_q)) == '0)); // R2
  AST_RETIRE_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_q && pend_q != '0) |=> (pend_q != $past(pend_q))); // R9
  AST_SERVE_PENDING_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((serve & ~pend_q) == '0)); // R9
endmodule

// File: tb/bsm_scratch_tb.sv
module bsm_scratch_tb_top;
  localparam int NT = 16;
  localparam int NB = 16;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                  start;
  logic [NT-1:0]         vld, wen;
  logic [NT-1:0][AW-1:0] adr;
  logic [NT-1:0][DW-1:0] wdt;
  logic                  busy, done;
  logic [NT-1:0][DW-1:0] rdd;

  bsm_scratch dut_i (
    .clk(clk), .rst(rst), .req_start(start), .req_valid(vld), .req_we(wen),
    .req_addr(adr), .req_wdata(wdt), .busy(busy), .done(done), .rd_data(rdd)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] model [1 << AW];

  logic [NT-1:0]         sv, sw;
  logic [NT-1:0][AW-1:0] sa;
  logic [NT-1:0][DW-1:0] sd;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // largest count of distinct valid addresses in one bank (R1, R3)
  function automatic int exp_cycles();
    int cnt [NB];
    int mx;
    foreach (cnt[i]) cnt[i] = 0;
    for (int t = 0; t < NT; t++) begin
      bit dup = 1'b0;
      if (sv[t]) begin
        for (int u = 0; u < t; u++)
          if (sv[u] && sa[u] == sa[t]) dup = 1'b1;
        if (!dup) cnt[sa[t] % NB]++;
      end
    end
    mx = 0;
    foreach (cnt[i]) if (cnt[i] > mx) mx = cnt[i];
    return (mx == 0) ? 1 : mx;
  endfunction

  task automatic run_set(string tag);
    int exp_n;
    int cnt;
    logic [NT-1:0][DW-1:0] exp_rd;
    exp_n = exp_cycles();
    for (int t = 0; t < NT; t++) exp_rd[t] = sv[t] ? model[sa[t]] : '0;
    @(negedge clk);
    start = 1'b1; vld = sv; wen = sw; adr = sa; wdt = sd;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R2", {tag, " busy after accept"}, busy, 1);
    // a second set offered while busy must be ignored (R2)
    vld = '1; wen = '1;
    for (int t = 0; t < NT; t++) begin
      adr[t] = AW'($urandom);
      wdt[t] = $urandom;
    end
    cnt = 0;
    while (cnt < 100) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0; vld = '0; wen = '0;
      if (done) break;
    end
    chk(cnt == exp_n + 1, "R3", {tag, " done latency"}, cnt, exp_n + 1);
    chk(busy == 1'b0, "R3", {tag, " busy low with done"}, busy, 0);
    for (int t = 0; t < NT; t++)
      chk(rdd[t] == exp_rd[t], sv[t] ? "R4" : "R6", {tag, " rd_data"}, rdd[t], exp_rd[t]);
    // R5: ascending order so the highest thread's write stays
    for (int t = 0; t < NT; t++)
      if (sv[t] && sw[t]) model[sa[t]] = sd[t];
  endtask

  task automatic read_all(string tag);
    for (int s = 0; s < (1 << AW) / NT; s++) begin
      sv = '1; sw = '0;
      for (int t = 0; t < NT; t++) begin
        sa[t] = AW'(s * NT + t);
        sd[t] = '0;
      end
      run_set(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    start = 1'b0; vld = '0; wen = '0; adr = '0; wdt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "idle in reset", {busy, done}, 0);
    chk(rdd == '0, "R8", "rd_data in reset", rdd[0], 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "idle after reset", {busy, done}, 0);

    // fill every word, stride 1: conflict free (R1)
    for (int s = 0; s < (1 << AW) / NT; s++) begin
      sv = '1; sw = '1;
      for (int t = 0; t < NT; t++) begin
        sa[t] = AW'(s * NT + t);
        sd[t] = $urandom;
      end
      run_set("R1 fill");
    end

    // R1: stride 16, same bank different rows -> 16 cycles
    sv = '1; sw = '0;
    for (int t = 0; t < NT; t++) sa[t] = AW'(37 + 16 * t);
    run_set("R1 stride16");

    // strides 2, 3, 8 reads
    for (int k = 0; k < 3; k++) begin
      int st;
      st = (k == 0) ? 2 : (k == 1) ? 3 : 8;
      sv = '1; sw = '0;
      for (int t = 0; t < NT; t++) sa[t] = AW'(100 + st * t);
      run_set("R3 stride");
    end

    // R4: broadcast, all threads same word -> 1 cycle
    sv = '1; sw = '0;
    for (int t = 0; t < NT; t++) sa[t] = 12'h2a5;
    run_set("R4 broadcast");

    // R5 / R4: mixed read and writes on one word
    sv = '0; sw = '0;
    sv[0] = 1'b1; sa[0] = 12'h0f3;
    sv[5] = 1'b1; sw[5] = 1'b1; sa[5] = 12'h0f3; sd[5] = 32'h5555_0005;
    sv[9] = 1'b1; sw[9] = 1'b1; sa[9] = 12'h0f3; sd[9] = 32'h9999_0009;
    sv[12] = 1'b1; sw[12] = 1'b1; sa[12] = 12'h1f3; sd[12] = 32'hcccc_000c;
    run_set("R5 same-word writes");
    sv = '1; sw = '0;
    for (int t = 0; t < NT; t++) sa[t] = (t < 8) ? 12'h0f3 : 12'h1f3;
    run_set("R5 readback");

    // R6/R3: empty set
    sv = '0; sw = '1;
    for (int t = 0; t < NT; t++) begin sa[t] = AW'(t); sd[t] = 32'hdead_0000; end
    run_set("R3 empty");

    // constrained random sets with invalid writers (R7)
    for (int i = 0; i < 300; i++) begin
      int span;
      span = (i % 3 == 0) ? 32 : (i % 3 == 1) ? 256 : 4096;
      sv = NT'($urandom);
      sw = NT'($urandom);
      for (int t = 0; t < NT; t++) begin
        sa[t] = AW'($urandom % span);
        sd[t] = $urandom;
      end
      run_set("R9 random");
    end

    read_all("R7 sweep");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule